// File: doc/BRIEF.md
# Cache Line Decay and Drowsy Controller

This block tracks the leakage state of a group of cache lines. Every line owns a small saturating age counter. An external decay pulse is divided down into age steps, and each step ages every line that was not touched. When a line's age reaches its maximum, the line is flagged drowsy: its array would be held at a retention voltage that keeps the stored data. One step later the line's tag is also flagged as powered down.

A requester presents an access with a line index. An access to an awake line completes at once. An access to a drowsy line is accepted, but the controller drops its ready output while the line is restored to full voltage: one cycle if only the data side sleeps, two cycles if the tag has also gone to sleep. A completion pulse marks the cycle in which the access is actually served. Every accepted access resets its line's age and wakes it.

Top module: `line_decay_ctrl`

## Requirements
- R1: After reset every age counter is 0, `line_drowsy` and `line_tag_off` are all zero, `acc_ready` is 1 and `acc_done` is 0.
- R2: One age step occurs on every STEP_DIV-th `decay_tick` pulse (default 2). A line with no accepted access becomes drowsy (its `line_drowsy` bit reads 1 in the cycle after the edge of the third step).
- R3: `line_tag_off` of a drowsy line rises on the first age step after the one that made it drowsy; `line_tag_off` is never 1 while `line_drowsy` is 0.
- R4: An access is accepted on an edge where `acc_req` and `acc_ready` are both 1. If the addressed line is awake, `acc_done` is 1 for the following cycle and `acc_ready` stays 1.
- R5: If the addressed line is drowsy with its tag on, `acc_ready` is 0 for exactly one cycle after acceptance, then `acc_ready` and `acc_done` are both 1 in the next cycle.
- R6: If the addressed line is drowsy with its tag off, `acc_ready` is 0 for exactly two cycles after acceptance, then `acc_ready` and `acc_done` are both 1.
- R7: An accepted access clears the line's counter, `line_drowsy` and `line_tag_off` at the acceptance edge; the line then needs three new age steps to become drowsy again.
- R8: When an age step and an accepted access hit the same line on one edge, the access wins and the line's counter ends at 0.
- R9: `acc_req` while `acc_ready` is 0 is ignored: it produces no completion and does not wake or reset the addressed line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| decay_tick | input | 1 | Decay pulse, divided by STEP_DIV into age steps |
| acc_req | input | 1 | Access request, taken when acc_ready is 1 |
| acc_idx | input | IDX_W | Line index of the access |
| acc_ready | output | 1 | 1 when a new access can be accepted; 0 during wake-up |
| acc_done | output | 1 | One-cycle pulse when an accepted access is served |
| line_drowsy | output | N_LINES | Per-line drowsy flag |
| line_tag_off | output | N_LINES | Per-line tag powered-down flag |

## Verification
Status flags are registered, so a step or access on an edge is visible in the cycle right after that edge; the bench drives inputs on the falling edge and compares on the next falling edge, one register later. Completion timing differs by wake case: one cycle after acceptance for an awake line, two for a drowsy line with its tag on, three with its tag off, and the bench counts `acc_ready` low cycles against exactly that. Directed sequences pin the third and fourth age steps, the same-edge step/access collision and requests during a stall, and a seeded random run compares every output on every cycle against a bench model.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_HOLD = 1'b1
  } ldc_wake_e;
endpackage

// File: rtl/ldc_tick_div.sv
module ldc_tick_div #(
  parameter int STEP_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic step
);
  generate
    if (STEP_DIV <= 1) begin : g_pass
      logic unused_pins;
      assign unused_pins = &{1'b0, clk, rst};
      assign step = tick_in;
    end else begin : g_div
      localparam int DW = $clog2(STEP_DIV);
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
        end else if (tick_in) begin
          div_q <= (div_q == DW'(STEP_DIV - 1)) ? '0 : div_q + 1'b1;
        end
      end
      assign step = tick_in && (div_q == DW'(STEP_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/ldc_line.sv
module ldc_line #(
  parameter int CNT_W   = 2,
  parameter int TAG_LAG = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic hit,
  output logic drowsy,
  output logic tag_off
);
  localparam logic [CNT_W-1:0] SAT    = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PRE    = SAT - 1'b1;
  localparam logic [CNT_W-1:0] TAG_AT = (TAG_LAG != 0) ? SAT : PRE;

  logic [CNT_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q   <= '0;
      drowsy  <= 1'b0;
      tag_off <= 1'b0;
    end else if (hit) begin
      age_q   <= '0;
      drowsy  <= 1'b0;
      tag_off <= 1'b0;
    end else if (step) begin
      if (age_q != SAT) age_q <= age_q + 1'b1;
      if (age_q == PRE) drowsy <= 1'b1;
      if (age_q == TAG_AT) tag_off <= 1'b1;
    end
  end
endmodule

// File: rtl/ldc_wake.sv
module ldc_wake
  import ldc_pkg::*;
#(
  parameter int N_LINES      = 8,
  parameter int IDX_W        = 3,
  parameter int WAKE_CYC     = 1,
  parameter int WAKE_TAG_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic [IDX_W-1:0]   idx,
  input  logic [N_LINES-1:0] drowsy_vec,
  input  logic [N_LINES-1:0] tag_vec,
  output logic               ready,
  output logic               done
);
  localparam int WMAX = (WAKE_TAG_CYC > WAKE_CYC) ? WAKE_TAG_CYC : WAKE_CYC;
  localparam int WW   = $clog2(WMAX + 1);

  ldc_wake_e      st_q;
  logic [WW-1:0]  wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= WK_IDLE;
      wait_q <= '0;
      ready  <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        WK_IDLE: begin
          if (req) begin
            if (drowsy_vec[idx]) begin
              st_q   <= WK_HOLD;
              ready  <= 1'b0;
              wait_q <= tag_vec[idx] ? WW'(WAKE_TAG_CYC - 1) : WW'(WAKE_CYC - 1);
            end else begin
              done <= 1'b1;
            end
          end
        end
        default: begin
          if (wait_q == '0) begin
            st_q  <= WK_IDLE;
            ready <= 1'b1;
            done  <= 1'b1;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/line_decay_ctrl.sv
module line_decay_ctrl #(
  parameter int N_LINES      = 8,
  parameter int IDX_W        = $clog2(N_LINES),
  parameter int CNT_W        = 2,
  parameter int STEP_DIV     = 2,
  parameter int TAG_LAG      = 1,
  parameter int WAKE_CYC     = 1,
  parameter int WAKE_TAG_CYC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               decay_tick,
  input  logic               acc_req,
  input  logic [IDX_W-1:0]   acc_idx,
  output logic               acc_ready,
  output logic               acc_done,
  output logic [N_LINES-1:0] line_drowsy,
  output logic [N_LINES-1:0] line_tag_off
);
  logic               age_step;
  logic               take;
  logic [N_LINES-1:0] hit_vec;

  assign take = acc_req && acc_ready;

  ldc_tick_div #(.STEP_DIV(STEP_DIV)) u_div (
    .clk(clk), .rst(rst), .tick_in(decay_tick), .step(age_step)
  );

  generate
    for (genvar i = 0; i < N_LINES; i++) begin : g_line
      assign hit_vec[i] = take && (acc_idx == IDX_W'(i));
      ldc_line #(.CNT_W(CNT_W), .TAG_LAG(TAG_LAG)) u_line (
        .clk(clk), .rst(rst), .step(age_step), .hit(hit_vec[i]),
        .drowsy(line_drowsy[i]), .tag_off(line_tag_off[i])
      );
    end
  endgenerate

  ldc_wake #(
    .N_LINES(N_LINES), .IDX_W(IDX_W),
    .WAKE_CYC(WAKE_CYC), .WAKE_TAG_CYC(WAKE_TAG_CYC)
  ) u_wake (
    .clk(clk), .rst(rst), .req(take), .idx(acc_idx),
    .drowsy_vec(line_drowsy), .tag_vec(line_tag_off),
    .ready(acc_ready), .done(acc_done)
  );
endmodule

// File: rtl/line_decay_ctrl_chk.sv
module line_decay_ctrl_chk #(
  parameter int N_LINES      = 8,
  parameter int IDX_W        = 3,
  parameter int WAKE_TAG_CYC = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               acc_req,
  input logic [IDX_W-1:0]   acc_idx,
  input logic               acc_ready,
  input logic               acc_done,
  input logic [N_LINES-1:0] line_drowsy,
  input logic [N_LINES-1:0] line_tag_off
);
  logic [7:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else if (!acc_ready) low_run <= low_run + 1'b1;
    else low_run <= '0;
  end

  assert_tag_needs_drowsy_R3: assert property (@(posedge clk) disable iff (rst)
    (line_tag_off & ~line_drowsy) == '0);

  assert_awake_done_R4: assert property (@(posedge clk) disable iff (rst)
    acc_ready && acc_req && !line_drowsy[acc_idx] |=> acc_done && acc_ready);

  assert_done_when_ready_R4: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> acc_ready);

  assert_drowsy_stall_R5: assert property (@(posedge clk) disable iff (rst)
    acc_ready && acc_req && line_drowsy[acc_idx] |=> !acc_ready);

  assert_tag_stall_R6: assert property (@(posedge clk) disable iff (rst)
    acc_ready && acc_req && line_tag_off[acc_idx] |=> !acc_ready ##1 !acc_ready);

  assert_stall_bound_R6: assert property (@(posedge clk) disable iff (rst)
    !acc_ready |-> low_run < 8'(WAKE_TAG_CYC));

  assert_resume_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_ready) |-> acc_done);

  assert_wake_clears_R7: assert property (@(posedge clk) disable iff (rst)
    acc_ready && acc_req |=> !line_drowsy[$past(acc_idx)] && !line_tag_off[$past(acc_idx)]);
endmodule

bind line_decay_ctrl line_decay_ctrl_chk #(
  .N_LINES(N_LINES), .IDX_W(IDX_W), .WAKE_TAG_CYC(WAKE_TAG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .acc_req(acc_req), .acc_idx(acc_idx),
  .acc_ready(acc_ready), .acc_done(acc_done),
  .line_drowsy(line_drowsy), .line_tag_off(line_tag_off)
);

// File: tb/line_decay_ctrl_test.sv
module line_decay_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int IW    = 3;
  localparam int DIV   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          decay_tick = 1'b0;
  logic          acc_req = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic          acc_ready, acc_done;
  logic [N-1:0]  line_drowsy, line_tag_off;

  int total = 0;
  int bad   = 0;

  int          m_cnt [N];
  logic [N-1:0] m_dr, m_tg;
  int          m_div, m_w;
  bit          m_ready, m_done;

  line_decay_ctrl #(.N_LINES(N), .STEP_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .decay_tick(decay_tick), .acc_req(acc_req),
    .acc_idx(acc_idx), .acc_ready(acc_ready), .acc_done(acc_done),
    .line_drowsy(line_drowsy), .line_tag_off(line_tag_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    m_dr = '0; m_tg = '0; m_div = 0; m_w = 0; m_ready = 1; m_done = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; decay_tick = 1'b0; acc_req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one cycle: drive at falling edge, predict, compare at next falling edge
  task automatic cyc(input bit t, input bit r, input int ix);
    bit stp;
    bit nd;
    logic [N-1:0] odr, otg;
    decay_tick = t; acc_req = r; acc_idx = ix[IW-1:0];
    stp = t && (m_div == DIV - 1);
    if (t) m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
    odr = m_dr; otg = m_tg; nd = 0;
    for (int i = 0; i < N; i++) begin
      if (m_ready && r && i == ix) begin
        m_cnt[i] = 0; m_dr[i] = 0; m_tg[i] = 0;
      end else if (stp) begin
        if (odr[i]) m_tg[i] = 1;
        if (m_cnt[i] == 2) m_dr[i] = 1;
        if (m_cnt[i] < 3) m_cnt[i]++;
      end
    end
    if (m_ready) begin
      if (r) begin
        if (odr[ix]) begin m_ready = 0; m_w = otg[ix] ? 1 : 0; end
        else nd = 1;
      end
    end else if (m_w == 0) begin
      m_ready = 1; nd = 1;
    end else begin
      m_w--;
    end
    m_done = nd;
    @(posedge clk);
    @(negedge clk);
    decay_tick = 1'b0; acc_req = 1'b0;
    chk(acc_ready == m_ready, "R5 ready", 32'(acc_ready), 32'(m_ready));
    chk(acc_done == m_done, "R4 done", 32'(acc_done), 32'(m_done));
    chk(line_drowsy == m_dr, "R2 drowsy", 32'(line_drowsy), 32'(m_dr));
    chk(line_tag_off == m_tg, "R3 tag_off", 32'(line_tag_off), 32'(m_tg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    do_reset();
    // R1 reset state
    chk(acc_ready == 1'b1, "R1 ready", 32'(acc_ready), 1);
    chk(acc_done == 1'b0, "R1 done", 32'(acc_done), 0);
    chk(line_drowsy == '0, "R1 drowsy", 32'(line_drowsy), 0);
    chk(line_tag_off == '0, "R1 tag_off", 32'(line_tag_off), 0);

    // R2: five pulses = two steps, sixth pulse = third step
    repeat (5) cyc(1, 0, 0);
    chk(line_drowsy == '0, "R2 before third step", 32'(line_drowsy), 0);
    cyc(1, 0, 0);
    chk(line_drowsy == '1, "R2 third step", 32'(line_drowsy), 32'hFF);
    chk(line_tag_off == '0, "R3 tag still on", 32'(line_tag_off), 0);
    cyc(1, 0, 0); cyc(1, 0, 0);
    chk(line_tag_off == '1, "R3 tag off next step", 32'(line_tag_off), 32'hFF);

    // R6: tag-off wake, two stall cycles
    cyc(0, 1, 3);
    chk(!acc_ready, "R6 stall 1", 32'(acc_ready), 0);
    cyc(0, 0, 0);
    chk(!acc_ready && !acc_done, "R6 stall 2", 32'(acc_ready), 0);
    cyc(0, 0, 0);
    chk(acc_ready && acc_done, "R6 resume", 32'({acc_ready, acc_done}), 3);
    chk(line_drowsy[3] == 1'b0 && line_tag_off[3] == 1'b0, "R7 line woken",
        32'({line_drowsy[3], line_tag_off[3]}), 0);

    // R9: request during stall is ignored
    cyc(0, 1, 4);
    cyc(0, 1, 5);
    chk(!acc_done, "R9 no done during stall", 32'(acc_done), 0);
    cyc(0, 0, 0);
    chk(acc_done, "R9 first access completes", 32'(acc_done), 1);
    cyc(0, 0, 0);
    chk(!acc_done, "R9 no second completion", 32'(acc_done), 0);
    chk(line_drowsy[5] && line_tag_off[5], "R9 line 5 untouched",
        32'({line_drowsy[5], line_tag_off[5]}), 3);

    // R5: drowsy with tag on, one stall cycle; then R4 awake access
    do_reset();
    repeat (6) cyc(1, 0, 0);
    cyc(0, 1, 2);
    chk(!acc_ready, "R5 stall", 32'(acc_ready), 0);
    cyc(0, 0, 0);
    chk(acc_ready && acc_done, "R5 resume", 32'({acc_ready, acc_done}), 3);
    cyc(0, 1, 2);
    chk(acc_ready && acc_done, "R4 awake access", 32'({acc_ready, acc_done}), 3);

    // R8: step and access on the same line, same edge
    do_reset();
    repeat (5) cyc(1, 0, 0);
    cyc(1, 1, 1);
    chk(line_drowsy == 8'hFD, "R8 access wins", 32'(line_drowsy), 32'hFD);
    repeat (4) cyc(1, 0, 0);
    chk(line_drowsy[1] == 1'b0, "R8 counter restarted at 0", 32'(line_drowsy[1]), 0);
    repeat (2) cyc(1, 0, 0);
    chk(line_drowsy[1] == 1'b1, "R7 drowsy after three new steps", 32'(line_drowsy[1]), 1);

    // seeded random traffic
    do_reset();
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 3) == 0, ($urandom % 5) == 0, int'($urandom % N));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule